// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block holds the interrupt state of an SD host. Command, data and card logic send single-cycle event pulses into it. A status-enable mask decides which of those events are recorded in a sticky status register. A second mask, the signal-enable mask, decides which recorded bits may raise the single interrupt line. Software clears a recorded event by writing a one to its bit. Writing a zero to a bit leaves it as it is.

Normal events use the low half of the status word and errors use the high half. A read-only summary bit in the status word shows whether any error is pending. The card interrupt is a level input rather than a pulse, so its status bit cannot be cleared while the card still holds the request. The register port is a 32-bit word-addressed interface with a write strobe and a read path that needs no read strobe.

Top module: `isc_host_irq`

## Requirements
- R1: Reset clears the status register, both enable registers and the interrupt output.
- R2: An event pulse at an event bit whose status-enable bit is 1 sets that status bit, and the bit is readable in the cycle after the clock edge that sampled the pulse. The normal event bits are 0 command done, 1 transfer done, 2 block gap, 3 DMA, 4 write buffer ready, 5 read buffer ready, 6 insertion and 7 removal. The error event bits are 16 command timeout, 17 command CRC, 18 command end bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end bit and 28 DMA error.
- R3: An event whose status-enable bit is 0 does not change the status register.
- R4: A write to word address 0 clears every event bit that has a 1 in the written data, and leaves every event bit that has a 0 unchanged.
- R5: If an event and a clearing write reach the same bit in the same cycle, the bit stays set.
- R6: The interrupt output is a register that holds the OR over all bits of (status AND signal-enable). It rises one clock edge after the status bit that causes it becomes visible.
- R7: A status bit whose signal-enable bit is 0 still latches but does not assert the interrupt. For example, masking bits 4 and 5 stops repeated buffer-ready interrupts.
- R8: Bit 15 of the status read value is the OR of status bits 31:16. Writes cannot change it, and it reads 0 in both enable registers.
- R9: Bits that are not event bits (9 to 14, 23 to 27 and 29 to 31) never latch. They read 0 in all registers, even after a write of all ones.
- R10: Bit 8 records the card-interrupt level input whenever status-enable bit 8 is 1. A clearing write has no effect while the level is high. Bit 8 of the event pulse vector is ignored.
- R11: The word addresses are 1 for status-enable and 2 for signal-enable. Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 status-enable, 2 signal-enable, 3 spare |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_pulse | input | 32 | Event pulses, one per status bit position |
| card_lvl | input | 1 | Card interrupt request level |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench drives inputs on the falling edge, and the read path is combinational. As a result, an event or a register write applied before a rising edge can be read back at the next falling edge. The interrupt output lags by one more edge. The bench checks that the interrupt is still low at the first falling edge and checks for its new value at the second. Bit sweeps cover every one of the 32 positions for latching, and every event bit for status gating and interrupt gating. The expected read values come from the bench's own event-bit list and summary rule.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CARD_BIT = 8;
  localparam int unsigned SUM_BIT  = 15;
  localparam int unsigned ERR_LSB  = 16;
  localparam int unsigned N_EN     = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS  = 2'd0,
    ADR_STAT_EN = 2'd1,
    ADR_SIG_EN  = 2'd2,
    ADR_SPARE   = 2'd3
  } isc_addr_e;

  // normal events 8:0, errors 22:16 and 28
  localparam logic [REG_W-1:0] EVT_BITS  = 32'h107F_01FF;
  localparam logic [REG_W-1:0] CARD_MASK = 32'h1 << CARD_BIT;
  localparam logic [REG_W-1:0] SUM_MASK  = 32'h1 << SUM_BIT;

  function automatic logic [REG_W-1:0] w1c_next(
      input logic [REG_W-1:0] cur, input logic [REG_W-1:0] clr,
      input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic err_summary(input logic [REG_W-1:0] v);
    return |v[REG_W-1:ERR_LSB];
  endfunction

  function automatic logic [REG_W-1:0] status_view(input logic [REG_W-1:0] v);
    return v | (err_summary(v) ? SUM_MASK : '0);
  endfunction
endpackage

// File: rtl/isc_enable_reg.sv
module isc_enable_reg
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] d_masked;
  assign d_masked = wdata & EVT_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d_masked;
  end

  assert_en_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q[SUM_BIT] == 1'b0));
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_vec,
  input  logic             card_lvl,
  input  logic [REG_W-1:0] stat_en,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] status
);
  logic [REG_W-1:0] raw_evt;
  logic [REG_W-1:0] set_vec;

  assign raw_evt = (evt_vec & ~CARD_MASK) | (card_lvl ? CARD_MASK : '0);
  assign set_vec = raw_evt & stat_en & EVT_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= w1c_next(status, clr_vec, set_vec);
  end

  // R2 and R5: a set in this cycle is visible next cycle, even when a clear hits it
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(stat_en)) == '0));
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen
  import isc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] status,
  input  logic [REG_W-1:0] sig_en,
  output logic             irq_q
);
  logic [REG_W-1:0] pend_vec;
  logic             pend_any;

  assign pend_vec = status & sig_en;
  assign pend_any = |pend_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec != '0) |=> irq_q);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & sig_en) == '0) |=> !irq_q);
endmodule

// File: rtl/isc_host_irq.sv
module isc_host_irq
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [REG_W-1:0]  evt_pulse,
  input  logic              card_lvl,
  output logic              irq
);
  logic [N_EN-1:0][REG_W-1:0] en_q;
  logic [REG_W-1:0]           status_q;
  logic [REG_W-1:0]           clr_vec;
  logic                       wr_status;

  assign wr_status = reg_wr && (reg_addr == ADR_STATUS);
  assign clr_vec   = wr_status ? (reg_wdata & EVT_BITS) : '0;

  // en_q[0] gates latching, en_q[1] gates signalling
  for (genvar gi = 0; gi < N_EN; gi++) begin : g_en
    localparam isc_addr_e MY_ADR = (gi == 0) ? ADR_STAT_EN : ADR_SIG_EN;
    logic wr_sel;
    assign wr_sel = reg_wr && (reg_addr == MY_ADR);
    isc_enable_reg u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_sel),
      .wdata (reg_wdata),
      .q     (en_q[gi])
    );
  end

  isc_status_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_vec  (evt_pulse),
    .card_lvl (card_lvl),
    .stat_en  (en_q[0]),
    .clr_vec  (clr_vec),
    .status   (status_q)
  );

  isc_irq_gen u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .sig_en (en_q[1]),
    .irq_q  (irq)
  );

  always_comb begin
    case (reg_addr)
      ADR_STATUS:  reg_rdata = status_view(status_q);
      ADR_STAT_EN: reg_rdata = en_q[0];
      ADR_SIG_EN:  reg_rdata = en_q[1];
      default:     reg_rdata = '0;
    endcase
  end

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_STATUS) |-> (reg_rdata[SUM_BIT] == (status_q[REG_W-1:ERR_LSB] != '0)));

  assert_unimpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~(EVT_BITS | SUM_MASK)) == '0));

  assert_spare_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_SPARE) |-> (reg_rdata == '0));
endmodule

// File: tb/isc_host_irq_tb.sv
module isc_host_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse = '0;
  logic        card_lvl = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_host_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .card_lvl(card_lvl), .irq(irq)
  );

  // bench's own view of which positions are pulse events
  function automatic bit is_pulse_evt(int b);
    return (b >= 0 && b <= 7) || (b >= 16 && b <= 22) || b == 28;
  endfunction

  function automatic logic [31:0] pulse_mask();
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) if (is_pulse_evt(b)) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] model_read(logic [31:0] st);
    logic any_err = 1'b0;
    for (int b = 16; b < 32; b++) any_err |= st[b];
    return any_err ? (st | 32'h0000_8000) : st;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] e);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pm;
    logic [31:0] st;
    pm = pulse_mask();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 stat_en", v, 32'h0);
    rd(2'd2, v); check("R1 sig_en", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R9 enable registers keep only event bits, R8 bit 15 reads 0
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R9 stat_en ones", v, pm | 32'h100);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R8 sig_en ones", v, pm | 32'h100);
    wr(2'd2, 32'h0);

    // R2/R9/R10 sweep: each of 32 pulse positions alone
    for (int b = 0; b < 32; b++) begin
      logic [31:0] one;
      one = 32'h1 << b;
      pulse(one);
      st = is_pulse_evt(b) ? one : 32'h0;
      rd(2'd0, v); check($sformatf("R2 R9 R10 latch bit %0d", b), v, model_read(st));
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check($sformatf("R4 clear bit %0d", b), v, 32'h0);
    end

    // R3 sweep: one event bit disabled at a time
    for (int b = 0; b < 32; b++) begin
      if (is_pulse_evt(b)) begin
        wr(2'd1, ~(32'h1 << b));
        pulse(32'hFFFF_FFFF);
        rd(2'd0, v); check($sformatf("R3 gate bit %0d", b), v, model_read(pm & ~(32'h1 << b)));
        wr(2'd0, 32'hFFFF_FFFF);
      end
    end
    wr(2'd1, 32'hFFFF_FFFF);

    // R4 partial clear and zero write
    pulse(32'hFFFF_FFFF);
    wr(2'd0, 32'h0);
    rd(2'd0, v); check("R4 zero write", v, model_read(pm));
    wr(2'd0, 32'h0055_0033);
    rd(2'd0, v); check("R4 pattern clear", v, model_read(pm & ~32'h0055_0033));
    wr(2'd0, 32'hFFFF_FFFF);

    // R5 event and clear on the same bit in the same cycle
    pulse(32'h3);
    evt_pulse = 32'h2;
    wr(2'd0, 32'h3);
    evt_pulse = '0;
    rd(2'd0, v); check("R5 set beats clear", v, 32'h2);
    wr(2'd0, 32'hFFFF_FFFF);

    // R6/R7 sweep over event bits
    for (int b = 0; b < 32; b++) begin
      if (is_pulse_evt(b)) begin
        logic [31:0] one;
        one = 32'h1 << b;
        wr(2'd2, one);
        pulse(one);
        check($sformatf("R6 irq lag bit %0d", b), {31'b0, irq}, 32'h0);
        @(negedge clk);
        check($sformatf("R6 irq bit %0d", b), {31'b0, irq}, 32'h1);
        wr(2'd2, pm & ~one);
        @(negedge clk);
        check($sformatf("R7 masked bit %0d", b), {31'b0, irq}, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
      end
    end

    // R7 buffer-ready masked, still latching
    wr(2'd2, pm & ~32'h30);
    pulse(32'h20);
    @(negedge clk);
    rd(2'd0, v); check("R7 latch while masked", v, 32'h20);
    check("R7 no irq", {31'b0, irq}, 32'h0);
    pulse(32'h1);
    @(negedge clk);
    check("R7 other bit irq", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 irq drops", {31'b0, irq}, 32'h0);
    wr(2'd2, 32'h0);

    // R8 summary bit
    pulse(32'h0010_0000);
    rd(2'd0, v); check("R8 summary set", v, 32'h0010_8000);
    wr(2'd0, 32'h0000_8000);
    rd(2'd0, v); check("R8 summary not writable", v, 32'h0010_8000);
    wr(2'd0, 32'h0010_0000);
    rd(2'd0, v); check("R8 summary clears", v, 32'h0);

    // R10 card level
    card_lvl = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R10 card latch", v, 32'h100);
    wr(2'd0, 32'h100);
    rd(2'd0, v); check("R10 clear while high", v, 32'h100);
    card_lvl = 1'b0;
    wr(2'd0, 32'h100);
    rd(2'd0, v); check("R10 clear after low", v, 32'h0);
    wr(2'd1, pm);
    card_lvl = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R10 card disabled", v, 32'h0);
    card_lvl = 1'b0;
    wr(2'd1, 32'hFFFF_FFFF);

    // R11 spare address
    wr(2'd2, 32'h0000_0003);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R11 spare reads 0", v, 32'h0);
    rd(2'd2, v); check("R11 sig_en untouched", v, 32'h3);
    rd(2'd1, v); check("R11 stat_en untouched", v, pm | 32'h100);
    rd(2'd0, v); check("R11 status untouched", v, 32'h0);

    // R1 reset in service
    pulse(32'h1);
    @(negedge clk);
    check("R1 pre-reset irq", {31'b0, irq}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 status after reset", v, 32'h0);
    rd(2'd1, v); check("R1 stat_en after reset", v, 32'h0);
    rd(2'd2, v); check("R1 sig_en after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule